// File: doc/BRIEF.md
# LDPC LLR Frame Collector

This block sits at the front of a layered LDPC decoder and gathers one codeword of soft input values before decoding starts. Each accepted beat carries a parameterised number of signed LLR lanes. Every column of the parity-check matrix is a group of `ceil(Z/LANES)` consecutive beats, where Z is the lifting size. The beats are written into a buffer addressed by (column, beat). The block takes the graph select, the lifting size and an iteration count on the start beat and holds them for the frame. When the final beat of the final column arrives together with the end marker, the frame is handed off.

Lanes beyond the lifting size in the last beat of a column are written as zero, which a decoder reads as a neutral LLR. If the lifting size given at start is not one of the legal values, the frame is dropped without any capture. A start during capture abandons the current frame and begins the new one. If the end marker arrives on the wrong beat, or does not arrive on the final beat, the frame is dropped and an error is flagged. A ready output tells the producer when a fresh frame can begin. The decoder reads the stored columns through a registered read port.

Top module: `ldpc_llr_collector`

## Requirements
- R1: `in_bg`=0 selects 66 columns and `in_bg`=1 selects 50. Each column takes `ceil(Z/LANES)` valid beats. `frm_done` pulses for one cycle, in the clock after the final beat, only when `in_end` is high on that final beat.
- R2: For column c, beat b and lane l, the LLR that was on `in_llr[l*LLR_W +: LLR_W]` at that beat is returned on `rd_llr` at the same lane position. It appears one clock after `rd_col`=c and `rd_beat`=b are applied.
- R3: In the last beat of each column, only lanes below `Z - LANES*(beats-1)` are kept. Higher lanes are stored as zero. All lanes of the other beats are kept.
- R4: Z is legal when Z = a·2^j with a in {2,3,5,7,9,11,13,15} and Z ≤ 384. An illegal Z on a start beat causes a `frm_drop` pulse, stores nothing, keeps `rdy` high and leaves `frm_z` unchanged.
- R5: A valid start during capture causes a `frm_drop` pulse for the abandoned frame. Capture then restarts at column 0 with the new frame's settings and data.
- R6: If `in_end` arrives before the final beat, or the final beat arrives without `in_end`, then `frm_err` and `frm_drop` pulse together, `frm_done` stays low and the block returns to idle.
- R7: With `ITER_FROM_PORT`=1, an `in_iter` value from 1 to 63 is latched into `frm_iter` unchanged, and any other value is replaced by `DEF_ITER` (8). With `ITER_FROM_PORT`=0, `frm_iter` is always `DEF_ITER`.
- R8: `rdy` is high in idle. It goes low from the clock after an accepted start and comes back high in the clock after the frame completes or is dropped.
- R9: `frm_bg`, `frm_z` and `frm_beats` (=`ceil(Z/LANES)`) are latched at a legal start and held until the next legal start.
- R10: A beat with `in_valid` low is ignored, even when `in_start` or `in_end` is high. It does not advance the position and does not write the buffer.
- R11: After reset, `rdy`=1, `frm_done`=`frm_drop`=`frm_err`=0 and `frm_iter`=`DEF_ITER`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_llr | input | LANES*LLR_W | Packed signed LLR lanes, lane 0 in the low bits |
| in_start | input | 1 | First beat of a frame |
| in_end | input | 1 | Final beat of a frame |
| in_valid | input | 1 | Beat qualifier |
| in_bg | input | 1 | Graph select: 0 gives 66 columns, 1 gives 50 |
| in_z | input | 16 | Lifting size, sampled on the start beat |
| in_iter | input | 8 | Requested iteration count, sampled on the start beat |
| rd_col | input | 7 | Read column |
| rd_beat | input | BW | Read beat within column |
| rdy | output | 1 | Ready for the start of a new frame |
| frm_done | output | 1 | Frame complete pulse |
| frm_drop | output | 1 | Frame discarded pulse |
| frm_err | output | 1 | Beat count mismatch pulse |
| frm_bg | output | 1 | Latched graph select |
| frm_z | output | 16 | Latched lifting size |
| frm_iter | output | 6 | Latched iteration count |
| frm_beats | output | BW | Beats per column of the latched frame |
| rd_llr | output | LANES*LLR_W | Stored LLR lanes at the read address |

## Verification
The hardest case to produce is the lane mask on a partial last beat, because it only shows when Z is not a multiple of the lane count. The bench therefore uses a four-lane build and sweeps every lifting size from 0 to 20 on alternating graphs, so that every remainder from 1 to 4 occurs together with legal and illegal sizes. Each frame is read back word by word. Restarting in mid-frame is reached by abandoning a partial frame and issuing a fresh start. The invalid beats inserted into every frame carry start and end high, so any leak of those flags would break the beat count.

// File: rtl/ldpc_coll_pkg.sv
package ldpc_coll_pkg;

  localparam int MAX_Z    = 384;
  localparam int COLS_BG0 = 66;
  localparam int COLS_BG1 = 50;
  localparam int COL_W    = 7;

  typedef enum logic [0:0] {ST_IDLE, ST_CAPT} coll_st_e;

  function automatic int max_beats(input int lanes);
    return (MAX_Z + lanes - 1) / lanes;
  endfunction

  // Legal when Z in [2, MAX_Z] and its odd part is at most 15.
  function automatic logic z_is_legal(input logic [15:0] z);
    logic [15:0] odd;
    logic        stop;
    odd  = z;
    stop = 1'b0;
    for (int i = 0; i < 16; i++) begin
      if (!stop && (odd != 16'd0) && !odd[0]) odd = odd >> 1;
      else stop = 1'b1;
    end
    return (z >= 16'd2) && (z <= 16'(MAX_Z)) && (odd <= 16'd15);
  endfunction

endpackage

// File: rtl/ldpc_lift_check.sv
module ldpc_lift_check
  import ldpc_coll_pkg::*;
#(
  parameter int LANES = 64,
  localparam int LSH  = $clog2(LANES),
  localparam int BW   = $clog2(max_beats(LANES) + 1),
  localparam int LW   = $clog2(LANES + 1)
) (
  input  logic [15:0]      z,
  input  logic             bg,
  output logic             legal,
  output logic [BW-1:0]    beats,
  output logic [COL_W-1:0] ncols,
  output logic [LW-1:0]    last_keep
);

  assign legal = z_is_legal(z);
  assign ncols = bg ? COL_W'(COLS_BG1) : COL_W'(COLS_BG0);

  always_comb begin
    beats     = '0;
    last_keep = '0;
    if (legal) begin
      beats     = BW'((32'(z) + LANES - 1) >> LSH);
      last_keep = LW'(32'(z) - (((32'(z) + LANES - 1) >> LSH) - 1) * LANES);
    end
  end

endmodule

// File: rtl/ldpc_lane_mask.sv
module ldpc_lane_mask #(
  parameter int LANES = 64,
  parameter int LLR_W = 6,
  localparam int LW   = $clog2(LANES + 1)
) (
  input  logic [LW-1:0]          keep,
  input  logic [LANES*LLR_W-1:0] din,
  output logic [LANES*LLR_W-1:0] dout
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign dout[i*LLR_W +: LLR_W] = (LW'(i) < keep) ? din[i*LLR_W +: LLR_W] : '0;
  end

endmodule

// File: rtl/ldpc_llr_store.sv
module ldpc_llr_store
  import ldpc_coll_pkg::*;
#(
  parameter int LANES = 64,
  parameter int LLR_W = 6,
  localparam int MAXB  = max_beats(LANES),
  localparam int BW    = $clog2(MAXB + 1),
  localparam int DEPTH = COLS_BG0 * MAXB,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LLR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [COL_W-1:0] wr_col,
  input  logic [BW-1:0]    wr_beat,
  input  logic [DW-1:0]    wr_data,
  input  logic [COL_W-1:0] rd_col,
  input  logic [BW-1:0]    rd_beat,
  output logic [DW-1:0]    rd_data
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wa, ra;
  logic          ra_ok;
  logic [DW-1:0] rd_d;

  assign wa    = AW'(int'(wr_col) * MAXB + int'(wr_beat));
  assign ra    = AW'(int'(rd_col) * MAXB + int'(rd_beat));
  assign ra_ok = (int'(rd_col) * MAXB + int'(rd_beat)) < DEPTH;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wa] <= wr_data;
  end

  always_comb begin
    rd_d = '0;
    if (ra_ok) rd_d = mem[ra];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_d;
  end

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_beat) < MAXB) && (int'(wr_col) < COLS_BG0)) else $error("write outside buffer"); // R2

endmodule

// File: rtl/ldpc_coll_ctrl.sv
module ldpc_coll_ctrl
  import ldpc_coll_pkg::*;
#(
  parameter int LANES          = 64,
  parameter bit ITER_FROM_PORT = 1'b1,
  parameter int DEF_ITER       = 8,
  localparam int BW = $clog2(max_beats(LANES) + 1),
  localparam int LW = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_start,
  input  logic             in_end,
  input  logic             in_valid,
  input  logic             in_bg,
  input  logic [15:0]      in_z,
  input  logic [7:0]       in_iter,
  input  logic             chk_legal,
  input  logic [BW-1:0]    chk_beats,
  input  logic [COL_W-1:0] chk_ncols,
  input  logic [LW-1:0]    chk_keep,
  output logic             wr_en,
  output logic [COL_W-1:0] wr_col,
  output logic [BW-1:0]    wr_beat,
  output logic [LW-1:0]    wr_keep,
  output logic             rdy,
  output logic             done,
  output logic             drop,
  output logic             err,
  output logic             frm_bg,
  output logic [15:0]      frm_z,
  output logic [5:0]       frm_iter,
  output logic [BW-1:0]    frm_beats
);

  coll_st_e         st_q, st_d;
  logic [COL_W-1:0] col_q, col_d, ncols_q;
  logic [BW-1:0]    beat_q, beat_d, beats_q;
  logic [LW-1:0]    keep_q;
  logic             bg_q;
  logic [15:0]      z_q;
  logic [5:0]       iter_q, iter_new;
  logic             done_q, drop_q, err_q, done_d, drop_d, err_d;
  logic             capt, st_beg, acc, cfg_en;
  logic             e_legal, col_end, is_last;
  logic [BW-1:0]    e_beats, p_beat;
  logic [COL_W-1:0] e_ncols, p_col;
  logic [LW-1:0]    e_keep;

  assign capt   = (st_q == ST_CAPT);
  assign st_beg = in_valid & in_start;
  assign acc    = in_valid & (in_start | capt);

  // Values that apply to the current beat: fresh on a start beat, latched otherwise.
  assign e_legal = st_beg ? chk_legal : 1'b1;
  assign e_beats = st_beg ? chk_beats : beats_q;
  assign e_ncols = st_beg ? chk_ncols : ncols_q;
  assign e_keep  = st_beg ? chk_keep  : keep_q;
  assign p_col   = st_beg ? '0 : col_q;
  assign p_beat  = st_beg ? '0 : beat_q;
  assign col_end = (p_beat == e_beats - BW'(1));
  assign is_last = col_end && (p_col == e_ncols - COL_W'(1));

  assign iter_new = (ITER_FROM_PORT && (in_iter >= 8'd1) && (in_iter <= 8'd63))
                    ? in_iter[5:0] : 6'(DEF_ITER);

  always_comb begin
    st_d   = st_q;
    col_d  = col_q;
    beat_d = beat_q;
    done_d = 1'b0;
    drop_d = 1'b0;
    err_d  = 1'b0;
    wr_en  = 1'b0;
    cfg_en = 1'b0;
    if (st_beg && capt) drop_d = 1'b1;
    if (acc) begin
      if (!e_legal) begin
        drop_d = 1'b1;
        st_d   = ST_IDLE;
      end else begin
        wr_en  = 1'b1;
        cfg_en = st_beg;
        if (in_end || is_last) begin
          st_d = ST_IDLE;
          if (in_end && is_last) done_d = 1'b1;
          else begin
            err_d  = 1'b1;
            drop_d = 1'b1;
          end
        end else begin
          st_d = ST_CAPT;
          if (col_end) begin
            beat_d = '0;
            col_d  = p_col + COL_W'(1);
          end else begin
            beat_d = p_beat + BW'(1);
            col_d  = p_col;
          end
        end
      end
    end
  end

  assign wr_col  = p_col;
  assign wr_beat = p_beat;
  assign wr_keep = col_end ? e_keep : LW'(LANES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      col_q  <= '0;
      beat_q <= '0;
      done_q <= 1'b0;
      drop_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      drop_q <= drop_d;
      err_q  <= err_d;
      if (acc) begin
        col_q  <= col_d;
        beat_q <= beat_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bg_q    <= 1'b0;
      z_q     <= '0;
      iter_q  <= 6'(DEF_ITER);
      beats_q <= '0;
      ncols_q <= '0;
      keep_q  <= '0;
    end else if (cfg_en) begin
      bg_q    <= in_bg;
      z_q     <= in_z;
      iter_q  <= iter_new;
      beats_q <= chk_beats;
      ncols_q <= chk_ncols;
      keep_q  <= chk_keep;
    end
  end

  assign rdy       = ~capt;
  assign done      = done_q;
  assign drop      = drop_q;
  assign err       = err_q;
  assign frm_bg    = bg_q;
  assign frm_z     = z_q;
  assign frm_iter  = iter_q;
  assign frm_beats = beats_q;

  AST_DONE_NOT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !drop_q) else $error("done with drop"); // R1
  AST_DONE_HAD_END: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(in_end && in_valid)) else $error("done without end"); // R1
  AST_BEAT_IN_COL: assert property (@(posedge clk) disable iff (!rst_n)
    capt |-> (beat_q < beats_q) && (col_q < ncols_q)) else $error("position past frame"); // R1
  AST_ERR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> drop_q) else $error("error without drop"); // R6
  AST_ITER_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    frm_iter != 6'd0) else $error("zero iterations"); // R7
  AST_RDY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> rdy) else $error("not ready after done"); // R8
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (capt && !st_beg) |=> $stable(z_q) && $stable(bg_q)) else $error("config moved"); // R9

endmodule

// File: rtl/ldpc_llr_collector.sv
module ldpc_llr_collector
  import ldpc_coll_pkg::*;
#(
  parameter int LANES          = 64,
  parameter int LLR_W          = 6,
  parameter bit ITER_FROM_PORT = 1'b1,
  parameter int DEF_ITER       = 8,
  localparam int BW = $clog2(max_beats(LANES) + 1),
  localparam int LW = $clog2(LANES + 1),
  localparam int DW = LANES * LLR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    in_llr,
  input  logic             in_start,
  input  logic             in_end,
  input  logic             in_valid,
  input  logic             in_bg,
  input  logic [15:0]      in_z,
  input  logic [7:0]       in_iter,
  input  logic [COL_W-1:0] rd_col,
  input  logic [BW-1:0]    rd_beat,
  output logic             rdy,
  output logic             frm_done,
  output logic             frm_drop,
  output logic             frm_err,
  output logic             frm_bg,
  output logic [15:0]      frm_z,
  output logic [5:0]       frm_iter,
  output logic [BW-1:0]    frm_beats,
  output logic [DW-1:0]    rd_llr
);

  logic             chk_legal;
  logic [BW-1:0]    chk_beats;
  logic [COL_W-1:0] chk_ncols;
  logic [LW-1:0]    chk_keep;
  logic             wr_en;
  logic [COL_W-1:0] wr_col;
  logic [BW-1:0]    wr_beat;
  logic [LW-1:0]    wr_keep;
  logic [DW-1:0]    wr_data;

  ldpc_lift_check #(.LANES(LANES)) u_lift (
    .z(in_z), .bg(in_bg), .legal(chk_legal), .beats(chk_beats),
    .ncols(chk_ncols), .last_keep(chk_keep)
  );

  ldpc_coll_ctrl #(.LANES(LANES), .ITER_FROM_PORT(ITER_FROM_PORT), .DEF_ITER(DEF_ITER)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_start(in_start), .in_end(in_end), .in_valid(in_valid),
    .in_bg(in_bg), .in_z(in_z), .in_iter(in_iter), .chk_legal(chk_legal),
    .chk_beats(chk_beats), .chk_ncols(chk_ncols), .chk_keep(chk_keep),
    .wr_en(wr_en), .wr_col(wr_col), .wr_beat(wr_beat), .wr_keep(wr_keep),
    .rdy(rdy), .done(frm_done), .drop(frm_drop), .err(frm_err), .frm_bg(frm_bg),
    .frm_z(frm_z), .frm_iter(frm_iter), .frm_beats(frm_beats)
  );

  ldpc_lane_mask #(.LANES(LANES), .LLR_W(LLR_W)) u_mask (
    .keep(wr_keep), .din(in_llr), .dout(wr_data)
  );

  ldpc_llr_store #(.LANES(LANES), .LLR_W(LLR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_col(wr_col), .wr_beat(wr_beat),
    .wr_data(wr_data), .rd_col(rd_col), .rd_beat(rd_beat), .rd_data(rd_llr)
  );

endmodule

// File: tb/ldpc_llr_collector_bench.sv
module ldpc_llr_collector_bench;

  localparam int LANES = 4;
  localparam int LLR_W = 6;
  localparam int BW    = 7;
  localparam int DW    = LANES * LLR_W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] in_llr = '0;
  logic          in_start = 1'b0, in_end = 1'b0, in_valid = 1'b0, in_bg = 1'b0;
  logic [15:0]   in_z = '0;
  logic [7:0]    in_iter = '0;
  logic [6:0]    rd_col = '0;
  logic [BW-1:0] rd_beat = '0;
  logic          rdy, frm_done, frm_drop, frm_err, frm_bg;
  logic [15:0]   frm_z;
  logic [5:0]    frm_iter;
  logic [BW-1:0] frm_beats;
  logic [DW-1:0] rd_llr;

  int total = 0;
  int bad   = 0;
  int last_z = 0;

  always #10 clk = ~clk;

  ldpc_llr_collector #(.LANES(LANES), .LLR_W(LLR_W), .ITER_FROM_PORT(1'b1), .DEF_ITER(8))
  u_ldpc_llr_collector (
    .clk(clk), .rst_n(rst_n), .in_llr(in_llr), .in_start(in_start), .in_end(in_end),
    .in_valid(in_valid), .in_bg(in_bg), .in_z(in_z), .in_iter(in_iter), .rd_col(rd_col),
    .rd_beat(rd_beat), .rdy(rdy), .frm_done(frm_done), .frm_drop(frm_drop),
    .frm_err(frm_err), .frm_bg(frm_bg), .frm_z(frm_z), .frm_iter(frm_iter),
    .frm_beats(frm_beats), .rd_llr(rd_llr)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit legal_model(input int z);
    int o;
    if (z < 2 || z > 384) return 1'b0;
    o = z;
    while (o % 2 == 0) o = o / 2;
    return o <= 15;
  endfunction

  function automatic logic [DW-1:0] pattern(input int seed, input int c, input int b);
    logic [DW-1:0] w;
    w = '0;
    for (int l = 0; l < LANES; l++) begin
      int v;
      v = ((c * 7 + b * 3 + l * 5 + seed) % 63) - 31;
      w[l*LLR_W +: LLR_W] = LLR_W'(v);
    end
    return w;
  endfunction

  function automatic logic [DW-1:0] masked(input logic [DW-1:0] w, input int keep);
    logic [DW-1:0] m;
    m = w;
    for (int l = 0; l < LANES; l++)
      if (l >= keep) m[l*LLR_W +: LLR_W] = '0;
    return m;
  endfunction

  // mode 0: normal end, 1: end early at beat cut, 2: no end, 3: abandon after cut beats
  task automatic send_frame(input bit bg, input int z, input int iter, input int seed,
                            input int mode, input int cut, input bit pre);
    int beats, ncols, nbeats, exp_iter;
    bit lg;
    lg     = legal_model(z);
    beats  = (z + LANES - 1) / LANES;
    ncols  = bg ? 50 : 66;
    nbeats = lg ? beats * ncols : 1;
    for (int k = 0; k < nbeats; k++) begin
      if (k % 7 == 3) begin
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b1; in_end = 1'b1; in_llr = '1;
      end
      @(negedge clk);
      if (k == 1) begin
        chk(rdy == 1'b0, "R8 rdy low in capture", rdy, 0);
        if (pre) chk(frm_drop == 1'b1, "R5 preempt drop", frm_drop, 1);
      end
      if (mode == 3 && k == cut) return;
      in_valid = 1'b1;
      in_start = (k == 0);
      in_end   = (mode == 0 && k == nbeats - 1) || (mode == 1 && k == cut);
      in_bg    = bg;
      in_z     = 16'(z);
      in_iter  = 8'(iter);
      in_llr   = pattern(seed, k / (beats > 0 ? beats : 1), k % (beats > 0 ? beats : 1));
      if (mode == 1 && k == cut) break;
    end
    @(negedge clk);
    in_valid = 1'b0; in_start = 1'b0; in_end = 1'b0;
    if (!lg) begin
      chk(frm_drop == 1'b1, "R4 illegal Z drop", frm_drop, 1);
      chk(rdy == 1'b1 && frm_done == 1'b0, "R4 illegal Z stays idle", {rdy, frm_done}, 2'b10);
      chk(int'(frm_z) == last_z, "R4 frm_z unchanged", frm_z, last_z);
      return;
    end
    last_z   = z;
    exp_iter = (iter >= 1 && iter <= 63) ? iter : 8;
    if (mode == 0) begin
      chk(frm_done && !frm_drop && !frm_err, "R1 done pulse", {frm_done, frm_drop, frm_err}, 3'b100);
      chk(rdy == 1'b1, "R8 rdy back high", rdy, 1);
    end else begin
      chk(frm_err && frm_drop && !frm_done, "R6 count mismatch", {frm_done, frm_drop, frm_err}, 3'b011);
    end
    chk(int'(frm_z) == z && frm_bg == bg && int'(frm_beats) == beats, "R9 latched config",
        {frm_bg, frm_z, 8'(frm_beats)}, {bg, 16'(z), 8'(beats)});
    chk(int'(frm_iter) == exp_iter, "R7 iteration count", frm_iter, exp_iter);
    @(negedge clk);
    chk(!frm_done && !frm_drop, "R1 single-cycle pulse", {frm_done, frm_drop}, 0);
  endtask

  task automatic verify(input bit bg, input int z, input int seed);
    int beats, ncols, keep;
    beats = (z + LANES - 1) / LANES;
    ncols = bg ? 50 : 66;
    for (int c = 0; c < ncols; c++) begin
      for (int b = 0; b < beats; b++) begin
        logic [DW-1:0] exp;
        @(negedge clk);
        rd_col  = 7'(c);
        rd_beat = BW'(b);
        @(negedge clk);
        keep = (b == beats - 1) ? z - LANES * (beats - 1) : LANES;
        exp  = masked(pattern(seed, c, b), keep);
        if (keep < LANES) chk(rd_llr == exp, "R3 masked lanes", rd_llr, exp);
        else              chk(rd_llr == exp, "R2 stored lanes", rd_llr, exp);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", total, 0);
    $display("test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdy && !frm_done && !frm_drop && !frm_err, "R11 reset outputs",
        {rdy, frm_done, frm_drop, frm_err}, 4'b1000);
    chk(frm_iter == 6'd8, "R11 reset iteration", frm_iter, 8);

    // Sweep lifting sizes, alternating graphs; R10 gap beats inside every frame.
    for (int z = 0; z <= 20; z++) begin
      send_frame(z[0], z, (z * 13) % 256, z, 0, 0, 1'b0);
      if (legal_model(z)) verify(z[0], z, z);
    end

    send_frame(1'b0, 384, 63, 5, 0, 0, 1'b0);
    send_frame(1'b1, 385, 5, 5, 0, 0, 1'b0);

    // R6: early end, and no end on the final beat
    send_frame(1'b1, 8, 3, 9, 1, 10, 1'b0);
    chk(rdy == 1'b1, "R6 idle after error", rdy, 1);
    send_frame(1'b0, 6, 70, 9, 2, 0, 1'b0);

    // R5: abandon a partial frame, then restart
    send_frame(1'b1, 6, 4, 11, 3, 20, 1'b0);
    send_frame(1'b0, 10, 200, 33, 0, 0, 1'b1);
    verify(1'b0, 10, 33);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule